// File: doc/BRIEF.md
# Urgency-Ordered Stable Matcher

This block computes the input-to-output pairing for one transfer phase of a combined input/output-queued crossbar switch that runs with fabric speedup. Each input keeps one virtual output queue per output. For every queue the caller presents the urgency of its head cell, which is the number of slots left before that cell must leave. The caller also presents a flag that marks the queue as empty. A start strobe launches the search. When the pairing is final, the block raises a single-cycle done strobe and then holds the result: for each output, the index of the input it was paired with, and a valid bit.

The search is a stable-marriage procedure in which outputs propose. Each free output tries its most urgent untried input. The input keeps whichever proposing output offers the more urgent cell. An output that is refused, or that is later displaced, moves on to its next candidate. The engine makes one proposal per clock, always on behalf of the lowest-numbered free output that still has a candidate. It finishes when no free output has an untried candidate left. At most N×N proposals are made, so the latency is bounded.

Top module: `urgency_matcher`

## Requirements
- R1: After reset, `done`, `busy` and every bit of `matchValid` are 0.
- R2: A `start` pulse while `busy` is 1 has no effect: the run completes with the same result and exactly one `done` pulse.
- R3: A pair is never matched when its queue's empty flag is 1 or its urgency code is 255, the reserved value for infinity. Urgency of input i for output j sits at bits [(i*N+j)*8 +: 8] of `urgencyIn`, and its empty flag at bit i*N+j of `emptyIn`.
- R4: The result is a matching: no input is reported for more than one valid output.
- R5: The result is stable. No usable pair (i, j) exists that is not matched together and in which output j prefers i and input i prefers j. A side that is unmatched prefers any usable partner.
- R6: The result equals the output-optimal stable matching under these rules. An output ranks inputs by smaller urgency first, then by lower input index. An input ranks outputs by smaller urgency first, then by lower output index. Output j's input index is at `matchIn[j*IDX_W +: IDX_W]`.
- R7: `done` is high for exactly one cycle, no later than N*N+3 cycles after the `start` edge. `busy` is high from the cycle after `start` until `done`.
- R8: After `done`, the result holds unchanged until the next accepted `start`, even if `urgencyIn` or `emptyIn` change.
- R9: When two outputs offer an input the same urgency, the lower-numbered output keeps the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new matching (accepted only when idle) |
| urgencyIn | input | N*N*URG_W | Head-cell urgency per queue, input-major |
| emptyIn | input | N*N | Queue empty flag per queue, input-major |
| busy | output | 1 | Matching in progress or finishing |
| done | output | 1 | One-cycle pulse when the result is final |
| matchIn | output | N*IDX_W | Matched input index per output |
| matchValid | output | N | Output has a partner |

## Verification
The bench builds the block with four ports and 8-bit urgency. At this size, hundreds of generated urgency matrices cover the situations that matter: dense ties, wide value spreads, reserved codes, sparse queues, and chains of displacement. An independent proposal model in the bench serves outputs in reverse order, which must still reach the same output-optimal result. A brute-force blocking-pair search checks stability on top of that. Directed cases cover ties at a single contested input, stray start pulses and input changes after completion.

// File: rtl/urgmatch_pkg.sv
package urgmatch_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clearAll;   // reset tried masks and holders
    logic doPropose;  // perform one proposal this cycle
    logic running;    // proposal phase active
  } ctrlStrobes_t;
endpackage

// File: rtl/urgmatch_min_pick.sv
module urgmatch_min_pick #(
  parameter int NPORT = 4,
  parameter int URG_W = 8,
  parameter int IDX_W = 2
) (
  input  logic [NPORT-1:0]       elig,
  input  logic [NPORT*URG_W-1:0] urgVec,
  output logic [IDX_W-1:0]       bestIdx,
  output logic [URG_W-1:0]       bestUrg
);
  logic found;
  // Smallest urgency wins; equal values keep the lower index
  always_comb begin
    found   = 1'b0;
    bestIdx = '0;
    bestUrg = '1;
    for (int i = 0; i < NPORT; i++) begin
      if (elig[i] && (!found || urgVec[i*URG_W +: URG_W] < bestUrg)) begin
        found   = 1'b1;
        bestIdx = IDX_W'(i);
        bestUrg = urgVec[i*URG_W +: URG_W];
      end
    end
  end
endmodule

// File: rtl/urgmatch_ctrl.sv
module urgmatch_ctrl import urgmatch_pkg::*; (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         anyCand,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         done
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_t;
  state_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start) stateNext = ST_RUN;
      ST_RUN:  if (!anyCand) stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    strobes.clearAll  = (state == ST_IDLE) && start;
    strobes.doPropose = (state == ST_RUN) && anyCand;
    strobes.running   = (state == ST_RUN);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: running out of candidates leads straight to completion
  assert_run_finishes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !anyCand) |=> done);
  // R2: a start seen mid-run does not drop the block back to idle
  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && start) |=> busy);
endmodule

// File: rtl/urgmatch_datapath.sv
module urgmatch_datapath import urgmatch_pkg::*; #(
  parameter int NPORT = 4,
  parameter int URG_W = 8,
  parameter int IDX_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrlStrobes_t             strobes,
  input  logic [NPORT*NPORT*URG_W-1:0] urgFlat,
  input  logic [NPORT*NPORT-1:0]   emptyFlat,
  output logic                     anyCand,
  output logic [NPORT*IDX_W-1:0]   matchIn,
  output logic [NPORT-1:0]         matchValid
);
  logic [NPORT-1:0]       tried   [NPORT];  // tried[out][in]
  logic [NPORT-1:0]       holdValid;        // per input
  logic [IDX_W-1:0]       holdOut [NPORT];
  logic [URG_W-1:0]       holdUrg [NPORT];
  logic [NPORT-1:0]       elig    [NPORT];  // elig[out][in]
  logic [NPORT*URG_W-1:0] colUrg  [NPORT];
  logic [IDX_W-1:0]       bestIdx [NPORT];
  logic [URG_W-1:0]       bestUrg [NPORT];
  logic [NPORT-1:0]       holdsOut[NPORT];  // holdsOut[out][in]
  logic [IDX_W-1:0]       matchVec[NPORT];
  logic [NPORT-1:0]       outMatched;
  logic [IDX_W-1:0]       propOut, propIn;
  logic [URG_W-1:0]       propUrg;
  logic                   accept;

  // Per-output column view and candidate selection
  for (genvar j = 0; j < NPORT; j++) begin : g_out
    for (genvar i = 0; i < NPORT; i++) begin : g_in
      assign colUrg[j][i*URG_W +: URG_W] = urgFlat[(i*NPORT+j)*URG_W +: URG_W];
      assign elig[j][i] = !emptyFlat[i*NPORT+j]
                        && (colUrg[j][i*URG_W +: URG_W] != {URG_W{1'b1}})
                        && !tried[j][i];
    end
    urgmatch_min_pick #(.NPORT(NPORT), .URG_W(URG_W), .IDX_W(IDX_W)) u_pick (
      .elig   (elig[j]),
      .urgVec (colUrg[j]),
      .bestIdx(bestIdx[j]),
      .bestUrg(bestUrg[j])
    );
    assign matchIn[j*IDX_W +: IDX_W] = matchVec[j];
  end

  // Output view of the input holders
  always_comb begin
    for (int j = 0; j < NPORT; j++) begin
      outMatched[j] = 1'b0;
      matchVec[j]   = '0;
      for (int i = 0; i < NPORT; i++) begin
        holdsOut[j][i] = holdValid[i] && (holdOut[i] == IDX_W'(j));
        if (holdsOut[j][i]) begin
          outMatched[j] = 1'b1;
          matchVec[j]   = IDX_W'(i);
        end
      end
    end
  end
  assign matchValid = outMatched;

  // Lowest-numbered free output with a remaining candidate proposes
  always_comb begin
    anyCand = 1'b0;
    propOut = '0;
    for (int j = NPORT-1; j >= 0; j--) begin
      if (!outMatched[j] && (|elig[j])) begin
        anyCand = 1'b1;
        propOut = IDX_W'(j);
      end
    end
  end

  assign propIn  = bestIdx[propOut];
  assign propUrg = bestUrg[propOut];
  assign accept  = !holdValid[propIn]
                || (propUrg < holdUrg[propIn])
                || ((propUrg == holdUrg[propIn]) && (propOut < holdOut[propIn]));

  always_ff @(posedge clk) begin
    if (!rst_n || strobes.clearAll) begin
      holdValid <= '0;
      for (int k = 0; k < NPORT; k++) begin
        tried[k]   <= '0;
        holdOut[k] <= '0;
        holdUrg[k] <= '0;
      end
    end else if (strobes.doPropose) begin
      tried[propOut][propIn] <= 1'b1;
      if (accept) begin
        holdValid[propIn] <= 1'b1;
        holdOut[propIn]   <= propOut;
        holdUrg[propIn]   <= propUrg;
      end
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    // R8: an input once paired stays paired until the next start
    assert_hold_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (holdValid[i] && !strobes.clearAll) |=> holdValid[i]);
    // R9: an input only trades up, ties resolved toward lower output
    assert_hold_improves_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (holdValid[i] && strobes.running) |=>
        (holdUrg[i] < $past(holdUrg[i])) ||
        ((holdUrg[i] == $past(holdUrg[i])) && (holdOut[i] <= $past(holdOut[i]))));
    // R3: a held pair refers to a non-empty queue during the run
    assert_hold_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (holdValid[i] && strobes.running) |-> !emptyFlat[i*NPORT + int'(holdOut[i])]);
  end
  for (genvar j = 0; j < NPORT; j++) begin : g_chk_out
    // R4: at most one input claims each output
    assert_single_partner_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(holdsOut[j]));
  end
endmodule

// File: rtl/urgency_matcher.sv
module urgency_matcher import urgmatch_pkg::*; #(
  parameter int NPORT = 4,
  parameter int URG_W = 8,
  localparam int IDX_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [NPORT*NPORT*URG_W-1:0] urgencyIn,
  input  logic [NPORT*NPORT-1:0]       emptyIn,
  output logic                         busy,
  output logic                         done,
  output logic [NPORT*IDX_W-1:0]       matchIn,
  output logic [NPORT-1:0]             matchValid
);
  ctrlStrobes_t strobes;
  logic         anyCand;

  urgmatch_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .anyCand(anyCand),
    .strobes(strobes),
    .busy   (busy),
    .done   (done)
  );

  urgmatch_datapath #(.NPORT(NPORT), .URG_W(URG_W), .IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .urgFlat   (urgencyIn),
    .emptyFlat (emptyIn),
    .anyCand   (anyCand),
    .matchIn   (matchIn),
    .matchValid(matchValid)
  );
endmodule

// File: tb/urgency_matcher_tb_top.sv
module urgency_matcher_tb_top;
  localparam int NP = 4;
  localparam int UW = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NP*NP*UW-1:0] urgencyIn = '0;
  logic [NP*NP-1:0]    emptyIn = '1;
  logic busy, done;
  logic [NP*IW-1:0] matchIn;
  logic [NP-1:0]    matchValid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int unsigned rng = 32'h1234_5678;

  logic [7:0] urg [NP][NP];   // urg[in][out]
  bit         emp [NP][NP];
  int         refOut [NP];    // expected input per output, -1 none

  always #5 clk = ~clk;

  urgency_matcher #(.NPORT(NP), .URG_W(UW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .urgencyIn(urgencyIn), .emptyIn(emptyIn),
    .busy(busy), .done(done), .matchIn(matchIn), .matchValid(matchValid)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: run hung, cycles=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int unsigned nextRand();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return rng;
  endfunction

  function automatic bit usable(int i, int j);
    return !emp[i][j] && (urg[i][j] != 8'hFF);
  endfunction

  task automatic check(bit ok, string tag, int got, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic packInputs();
    for (int i = 0; i < NP; i++)
      for (int j = 0; j < NP; j++) begin
        urgencyIn[(i*NP+j)*UW +: UW] = urg[i][j];
        emptyIn[i*NP+j] = emp[i][j];
      end
  endtask

  // Independent proposal model: outputs served from high index down
  task automatic computeRef();
    int  holdO [NP];
    bit  triedR [NP][NP];
    bit  progress;
    for (int i = 0; i < NP; i++) begin
      holdO[i] = -1;
      for (int j = 0; j < NP; j++) triedR[j][i] = 0;
    end
    do begin
      progress = 0;
      for (int j = NP-1; j >= 0; j--) begin
        bit isFree = 1;
        int best = -1;
        for (int i = 0; i < NP; i++) if (holdO[i] == j) isFree = 0;
        if (isFree) begin
          for (int i = 0; i < NP; i++)
            if (usable(i, j) && !triedR[j][i] && (best < 0 || urg[i][j] < urg[best][j]))
              best = i;
          if (best >= 0) begin
            triedR[j][best] = 1;
            progress = 1;
            if (holdO[best] < 0 || urg[best][j] < urg[best][holdO[best]] ||
                (urg[best][j] == urg[best][holdO[best]] && j < holdO[best]))
              holdO[best] = j;
          end
        end
      end
    end while (progress);
    for (int j = 0; j < NP; j++) begin
      refOut[j] = -1;
      for (int i = 0; i < NP; i++) if (holdO[i] == j) refOut[j] = i;
    end
  endtask

  function automatic int gotIn(int j);
    return matchValid[j] ? int'(matchIn[j*IW +: IW]) : -1;
  endfunction

  // R3 R4 R5 R6 on the present outputs
  task automatic checkResult(int trial);
    bit okR3 = 1, okR4 = 1, okR5 = 1, okR6 = 1;
    int pOut [NP];
    int pIn  [NP];
    for (int k = 0; k < NP; k++) begin pOut[k] = -1; pIn[k] = -1; end
    for (int j = 0; j < NP; j++) begin
      int g = gotIn(j);
      if (g != refOut[j]) begin
        okR6 = 0;
        $display("FAIL R6 trial %0d out %0d: got %0d expected %0d", trial, j, g, refOut[j]);
      end
      if (g >= 0) begin
        if (!usable(g, j)) okR3 = 0;
        if (pIn[g] >= 0) okR4 = 0;
        pIn[g] = j;
        pOut[j] = g;
      end
    end
    for (int i = 0; i < NP; i++)
      for (int j = 0; j < NP; j++)
        if (usable(i, j) && pOut[j] != i) begin
          bit outWants, inWants;
          int p = pOut[j];
          int k = pIn[i];
          outWants = (p < 0) || (urg[i][j] < urg[p][j]) || (urg[i][j] == urg[p][j] && i < p);
          inWants  = (k < 0) || (urg[i][j] < urg[i][k]) || (urg[i][j] == urg[i][k] && j < k);
          if (outWants && inWants) okR5 = 0;
        end
    check(okR6, "R6 output-optimal result", okR6, 1);
    check(okR3, "R3 empty or reserved pair matched", okR3, 1);
    check(okR4, "R4 input shared by outputs", okR4, 1);
    check(okR5, "R5 blocking pair present", okR5, 1);
  endtask

  task automatic runTrial(int trial, bit strayStart, bit holdTest);
    int  lat = 0;
    int  doneCount = 0;
    bit  busyOk = 1;
    packInputs();
    computeRef();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (lat < 100) begin
      lat++;
      if (done) break;
      if (!busy) busyOk = 0;
      if (strayStart && lat == 1) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    doneCount = done ? 1 : 0;
    check(lat <= NP*NP+3 && done, "R7 done latency", lat, NP*NP+3);
    check(busyOk, "R7 busy during run", busyOk, 1);
    checkResult(trial);
    @(negedge clk);
    check(!done, "R7 done single cycle", done, 0);
    if (strayStart) begin
      for (int c = 0; c < 20; c++) begin
        if (done) doneCount++;
        @(negedge clk);
      end
      check(doneCount == 1, "R2 stray start gave extra run", doneCount, 1);
      checkResult(trial);
    end
    if (holdTest) begin
      for (int i = 0; i < NP; i++)
        for (int j = 0; j < NP; j++) begin emp[i][j] = 1; urg[i][j] = 8'hFF; end
      packInputs();
      repeat (3) @(negedge clk);
      for (int j = 0; j < NP; j++)
        check(gotIn(j) == refOut[j], "R8 result held after done", gotIn(j), refOut[j]);
    end
  endtask

  task automatic fillRandom(int mode);
    for (int i = 0; i < NP; i++)
      for (int j = 0; j < NP; j++) begin
        int unsigned r = nextRand();
        case (mode)
          0: begin urg[i][j] = 8'(r % 4);   emp[i][j] = ((r >> 8) % 4) == 0; end
          1: begin urg[i][j] = 8'(r % 255); emp[i][j] = ((r >> 8) % 5) == 0; end
          2: begin urg[i][j] = ((r >> 4) % 3 == 0) ? 8'hFF : 8'(r % 8); emp[i][j] = 0; end
          default: begin urg[i][j] = 8'd7; emp[i][j] = ((r >> 8) % 2) == 0; end
        endcase
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !busy && matchValid == '0, "R1 reset state", int'(matchValid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: two outputs tie on input 1; lower output keeps it
    for (int i = 0; i < NP; i++)
      for (int j = 0; j < NP; j++) begin emp[i][j] = 1; urg[i][j] = 8'd9; end
    emp[1][0] = 0; urg[1][0] = 8'd1;
    emp[1][1] = 0; urg[1][1] = 8'd1;
    runTrial(0, 0, 0);
    check(matchValid[0] && matchIn[1:0] == 2'd1, "R9 tie to lower output", gotIn(0), 1);
    check(!matchValid[1], "R9 higher output loses tie", matchValid[1], 0);

    // R9: all equal urgency gives identity pairing
    for (int i = 0; i < NP; i++)
      for (int j = 0; j < NP; j++) begin emp[i][j] = 0; urg[i][j] = 8'd5; end
    runTrial(1, 0, 0);
    for (int j = 0; j < NP; j++) check(gotIn(j) == j, "R9 equal urgency identity", gotIn(j), j);

    // R3: everything reserved infinity -> nothing matched
    for (int i = 0; i < NP; i++)
      for (int j = 0; j < NP; j++) begin emp[i][j] = 0; urg[i][j] = 8'hFF; end
    runTrial(2, 0, 0);
    check(matchValid == '0, "R3 all reserved unmatched", int'(matchValid), 0);

    // R3: all empty -> nothing matched
    for (int i = 0; i < NP; i++)
      for (int j = 0; j < NP; j++) begin emp[i][j] = 1; urg[i][j] = 8'd0; end
    runTrial(3, 0, 0);
    check(matchValid == '0, "R3 all empty unmatched", int'(matchValid), 0);

    // Sweep of generated matrices, with stray starts (R2) and hold tests (R8)
    for (int t = 0; t < 400; t++) begin
      fillRandom(t % 4);
      runTrial(10 + t, (t % 7) == 3, (t % 11) == 5);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule